// File: doc/BRIEF.md
# Hot-plug slot register controller

This block holds the slot control and slot status registers of a hot-plug capable downstream or root port. Software reaches both through a 16-bit register port with byte enables. Slot hardware reports attention-button presses, power faults, hot-add insertions and hot-remove requests on single-cycle event inputs. The block records each event as a status bit. It then decides from the per-event enables and the master hot-plug interrupt enable whether an interrupt is pending.

A pending change is signalled in one of two ways. When message interrupts are selected, the block emits a one-cycle pulse that carries the interrupt message number. Otherwise, a level interrupt follows the pending flag. Every write to slot control counts as one command. The command takes effect at once and then raises a command-completed event. Such a write can also toggle the electromechanical interlock state or order the slot's device to be detached. Power sequencing and the interlock mechanics live outside this block.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x03E0 when a power controller is present and the slot starts empty. In that value, attention indicator bits [6:5] = 11 (off), power indicator bits [8:7] = 11 (off), power-off bit [9] = 1, and all enables are 0. Slot status reads 0x0000.
- R2: The pending flag is set when the hot-plug interrupt enable (control bit 4) is 1 and at least one event status bit [3:0] is set with its enable in control bits [3:0]. With message mode off, `irq_level` equals the pending flag one clock after the register update.
- R3: With message mode on, a change of the pending flag produces `irq_pulse` high for exactly one cycle, one clock after the register update, with `irq_vec` equal to `msg_vec`. No pulse occurs while the flag is unchanged.
- R4: Status event bits are write-1-to-clear: button [0], power fault [1], presence changed [2], command done [3]. A status write re-evaluates the pending flag without a pulse, and with message mode off it drops `irq_level` when nothing remains pending.
- R5: An event whose status bit is already set causes no new pulse.
- R6: Any slot control write with at least one byte enable is one command. It sets the command-done bit [3] on the same edge, which notifies if that bit is enabled.
- R7: Control bit 10 always reads 0. Writing 1 to it (upper byte enabled) inverts the interlock status bit [5].
- R8: A control write with the upper byte enabled, presence bit [4] set, the resulting power-off bit [9] = 1 and power indicator = 11 pulses `detach_req` for one cycle. The same write clears presence and sets presence changed.
- R9: While the interlock bit is set, a hot-add pulses `add_busy` and changes no status. Otherwise, a hot-add sets presence and both the presence-changed and button bits.
- R10: A hot-remove request sets the button status bit.
- R11: Only bytes whose enable is set are written. The lower byte covers control bits [7:0], and the upper byte covers bits [10:8].
- R12: Register writes are visible on `reg_rdata` right after the clock edge that takes them (`reg_sel` 0 = control, 1 = status).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects slot control, 1 selects slot status |
| reg_be | input | 2 | Byte enables of the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read of the selected register |
| ev_btn | input | 1 | Attention button pressed |
| ev_pfault | input | 1 | Power fault detected |
| ev_add | input | 1 | Hot-add of a device |
| ev_remove | input | 1 | Hot-remove request |
| add_busy | output | 1 | Hot-add refused because the interlock is engaged |
| msg_mode | input | 1 | 1 selects message-interrupt signalling |
| msg_vec | input | 5 | Interrupt message number |
| irq_pulse | output | 1 | One-cycle message interrupt |
| irq_vec | output | 5 | Message number of the last pulse |
| irq_level | output | 1 | Level interrupt |
| detach_req | output | 1 | One-cycle request to detach the slot device |

## Verification
The bench builds the block with a power controller present and the slot empty at reset. This makes the power-off bit writable and gives the detach path a real trigger. Under this configuration, every 32 values of the hot-plug and event enables are swept against button, power-fault, hot-add and command events, so each combination of the pending flag is reached. The lock toggle, refused hot-add, byte-masked writes and detach order then follow with a populated slot.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W    = 16;
  localparam int EV_N     = 4;
  localparam int CTL_W    = 10;
  localparam int STS_W    = 6;

  // event status / enable positions
  localparam int SB_BTN    = 0;
  localparam int SB_PFAULT = 1;
  localparam int SB_PDC    = 2;
  localparam int SB_CMD    = 3;
  localparam int CB_LOCK_T = 10;

  localparam logic [1:0] IND_ON    = 2'b01;
  localparam logic [1:0] IND_BLINK = 2'b10;
  localparam logic [1:0] IND_OFF   = 2'b11;

  typedef struct packed {
    logic            pwr_off;   // [9]
    logic [1:0]      pwr_ind;   // [8:7]
    logic [1:0]      attn_ind;  // [6:5]
    logic            hp_ie;     // [4]
    logic [EV_N-1:0] ev_en;     // [3:0]
  } slot_ctl_t;

  typedef struct packed {
    logic            lock;      // [5]
    logic            pres;      // [4]
    logic [EV_N-1:0] ev;        // [3:0]
  } slot_sts_t;
endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL  = 1'b1,
  parameter bit POP_AT_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [1:0]       reg_be,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_btn,
  input  logic             ev_pfault,
  input  logic             ev_add,
  input  logic             ev_remove,
  output slot_ctl_t        ctl_q,
  output slot_sts_t        sts_q,
  output logic             quiet_upd,
  output logic             detach_req,
  output logic             add_busy
);
  localparam logic [CTL_W-1:0] CTL_WMASK = HAS_PWR_CTL ? 10'h3FF : 10'h1FF;
  localparam logic             RST_PWR_OFF = HAS_PWR_CTL && !POP_AT_RESET;
  localparam logic [1:0]       RST_PWR_IND = !HAS_PWR_CTL ? 2'b00 :
                                             (POP_AT_RESET ? IND_ON : IND_OFF);
  localparam slot_ctl_t CTL_RST = '{pwr_off: RST_PWR_OFF, pwr_ind: RST_PWR_IND,
                                    attn_ind: IND_OFF, hp_ie: 1'b0, ev_en: '0};
  localparam slot_sts_t STS_RST = '{lock: 1'b0, pres: POP_AT_RESET, ev: '0};

  logic             ctl_wr, sts_wr, lock_tgl, add_ok;
  logic [REG_W-1:0] bmask;
  logic [CTL_W-1:0] wr_bits;
  slot_ctl_t        ctl_d;
  slot_sts_t        sts_d;
  logic [EV_N-1:0]  ev_set, ev_clr;
  logic             detach_d, busy_d, quiet_d;

  // byte lane mask
  for (genvar b = 0; b < REG_W / 8; b++) begin : g_lane
    assign bmask[b*8 +: 8] = {8{reg_be[b]}};
  end

  always_comb begin
    ctl_wr   = reg_wr && !reg_sel && (|reg_be);
    sts_wr   = reg_wr &&  reg_sel && (|reg_be);
    wr_bits  = bmask[CTL_W-1:0] & CTL_WMASK;
    ctl_d    = ctl_q;
    if (ctl_wr) begin
      ctl_d = slot_ctl_t'((ctl_q & ~wr_bits) | (reg_wdata[CTL_W-1:0] & wr_bits));
    end
    lock_tgl = ctl_wr && reg_be[1] && reg_wdata[CB_LOCK_T];
    detach_d = ctl_wr && reg_be[1] && sts_q.pres && ctl_d.pwr_off &&
               (ctl_d.pwr_ind == IND_OFF);
    add_ok   = ev_add && !sts_q.lock;
    busy_d   = ev_add &&  sts_q.lock;

    ev_set           = '0;
    ev_set[SB_BTN]    = ev_btn || ev_remove || add_ok;
    ev_set[SB_PFAULT] = ev_pfault;
    ev_set[SB_PDC]    = add_ok || detach_d;
    ev_set[SB_CMD]    = ctl_wr;
    ev_clr           = sts_wr ? (reg_wdata[EV_N-1:0] & bmask[EV_N-1:0]) : '0;

    sts_d      = sts_q;
    sts_d.ev   = (sts_q.ev & ~ev_clr) | ev_set;
    sts_d.lock = sts_q.lock ^ lock_tgl;
    if (add_ok) begin
      sts_d.pres = 1'b1;
    end else if (detach_d) begin
      sts_d.pres = 1'b0;
    end
    quiet_d = sts_wr && !(|ev_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= CTL_RST;
      sts_q      <= STS_RST;
      quiet_upd  <= 1'b0;
      detach_req <= 1'b0;
      add_busy   <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      sts_q      <= sts_d;
      quiet_upd  <= quiet_d;
      detach_req <= detach_d;
      add_busy   <= busy_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) reg_rdata[STS_W-1:0] = sts_q;
    else         reg_rdata[CTL_W-1:0] = ctl_q;
  end

  AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sts_q.ev[SB_CMD]); // R6
  AST_LOCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_tgl |=> (sts_q.lock != $past(sts_q.lock))); // R7
  AST_DETACH_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (detach_req && !$past(ev_add)) |-> (!sts_q.pres && sts_q.ev[SB_PDC])); // R8
  AST_BUSY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    add_busy |-> $past(sts_q.lock)); // R9
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
  import hp_slot_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_ctl_t        ctl_q,
  input  slot_sts_t        sts_q,
  input  logic             quiet_upd,
  input  logic             msg_mode,
  input  logic [VEC_W-1:0] msg_vec,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_level
);
  logic             pend_now, pend_q, fire;
  logic             level_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    pend_now = ctl_q.hp_ie && (|(sts_q.ev & ctl_q.ev_en));
    fire     = (pend_now != pend_q) && !quiet_upd && msg_mode;
    vec_d    = fire ? msg_vec : irq_vec;
    level_d  = msg_mode ? irq_level : pend_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
      irq_level <= 1'b0;
    end else begin
      pend_q    <= pend_now;
      irq_pulse <= fire;
      irq_vec   <= vec_d;
      irq_level <= level_d;
    end
  end

  AST_PULSE_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(msg_mode)); // R3
  AST_QUIET_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(quiet_upd) |-> !irq_pulse); // R4
  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(msg_mode) && !$past(ctl_q.hp_ie)) |-> !irq_level); // R2
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
#(
  parameter bit HAS_PWR_CTL  = 1'b1,
  parameter bit POP_AT_RESET = 1'b0,
  parameter int VEC_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [1:0]       reg_be,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             ev_btn,
  input  logic             ev_pfault,
  input  logic             ev_add,
  input  logic             ev_remove,
  output logic             add_busy,
  input  logic             msg_mode,
  input  logic [VEC_W-1:0] msg_vec,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_level,
  output logic             detach_req
);
  slot_ctl_t ctl_q;
  slot_sts_t sts_q;
  logic      quiet_upd;

  hp_slot_regs #(
    .HAS_PWR_CTL (HAS_PWR_CTL),
    .POP_AT_RESET(POP_AT_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_btn    (ev_btn),
    .ev_pfault (ev_pfault),
    .ev_add    (ev_add),
    .ev_remove (ev_remove),
    .ctl_q     (ctl_q),
    .sts_q     (sts_q),
    .quiet_upd (quiet_upd),
    .detach_req(detach_req),
    .add_busy  (add_busy)
  );

  hp_slot_notify #(
    .VEC_W(VEC_W)
  ) u_notify (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_q    (ctl_q),
    .sts_q    (sts_q),
    .quiet_upd(quiet_upd),
    .msg_mode (msg_mode),
    .msg_vec  (msg_vec),
    .irq_pulse(irq_pulse),
    .irq_vec  (irq_vec),
    .irq_level(irq_level)
  );
endmodule

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel;
  logic [1:0]  reg_be;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ev_btn, ev_pfault, ev_add, ev_remove, add_busy;
  logic        msg_mode;
  logic [4:0]  msg_vec, irq_vec;
  logic        irq_pulse, irq_level, detach_req;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hp_slot_ctrl u_hp_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_btn(ev_btn), .ev_pfault(ev_pfault), .ev_add(ev_add),
    .ev_remove(ev_remove), .add_busy(add_busy), .msg_mode(msg_mode),
    .msg_vec(msg_vec), .irq_pulse(irq_pulse), .irq_vec(irq_vec),
    .irq_level(irq_level), .detach_req(detach_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 2'b00; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  // which: 0 button, 1 power fault, 2 hot-add, 3 hot-remove
  task automatic ev(input int which);
    ev_btn = (which == 0); ev_pfault = (which == 1);
    ev_add = (which == 2); ev_remove = (which == 3);
    @(negedge clk);
    ev_btn = 0; ev_pfault = 0; ev_add = 0; ev_remove = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; reg_wr = 0; reg_sel = 0; reg_be = 0; reg_wdata = 0;
    ev_btn = 0; ev_pfault = 0; ev_add = 0; ev_remove = 0;
    msg_mode = 0; msg_vec = 5'h13;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 ctrl reset", v, 16'h03E0);
    rd(1, v); chk("R1 status reset", v, 16'h0000);
    chk("R1 level reset", {15'b0, irq_level}, 16'h0);
    chk("R1 pulse reset", {15'b0, irq_pulse}, 16'h0);

    // R2/R4/R6/R9 sweep over all enable combinations, level mode
    for (int e = 0; e < 32; e++) begin
      logic [4:0] en;
      en = e[4:0];
      wr(0, 2'b01, {8'h00, 3'b111, en});
      rd(0, v); chk("R12 ctrl low byte", {8'h00, v[7:0]}, {8'h00, 3'b111, en});
      @(negedge clk);
      chk("R6 level after command", {15'b0, irq_level}, {15'b0, en[4] & en[3]});
      wr(1, 2'b01, 16'h000F);
      rd(1, v); chk("R4 status cleared", {12'b0, v[3:0]}, 16'h0);
      @(negedge clk);
      chk("R4 level dropped", {15'b0, irq_level}, 16'h0);
      ev(0); @(negedge clk);
      chk("R2 level button", {15'b0, irq_level}, {15'b0, en[4] & en[0]});
      ev(1); @(negedge clk);
      chk("R2 level pfault", {15'b0, irq_level}, {15'b0, en[4] & (en[0] | en[1])});
      ev(2); @(negedge clk);
      chk("R9 level hot-add", {15'b0, irq_level},
          {15'b0, en[4] & (en[0] | en[1] | en[2])});
      rd(1, v); chk("R9 hot-add status", v, 16'h0017);
      chk("R3 no pulse in level mode", {15'b0, irq_pulse}, 16'h0);
      wr(1, 2'b01, 16'h000F);
      @(negedge clk);
    end

    // message mode
    msg_mode = 1;
    wr(0, 2'b01, 16'h00F1);
    @(negedge clk);
    chk("R3 no pulse without change", {15'b0, irq_pulse}, 16'h0);
    ev(3);
    rd(1, v); chk("R10 remove sets button", {15'b0, v[0]}, 16'h1);
    @(negedge clk);
    chk("R3 pulse on change", {15'b0, irq_pulse}, 16'h1);
    chk("R3 vector", {11'b0, irq_vec}, 16'h0013);
    @(negedge clk);
    chk("R3 pulse one cycle", {15'b0, irq_pulse}, 16'h0);
    ev(0); @(negedge clk);
    chk("R5 repeated event no pulse", {15'b0, irq_pulse}, 16'h0);
    wr(1, 2'b01, 16'h0001);
    @(negedge clk);
    chk("R4 status write no pulse", {15'b0, irq_pulse}, 16'h0);
    wr(0, 2'b01, 16'h00F9);
    @(negedge clk);
    chk("R6 command done notifies", {15'b0, irq_pulse}, 16'h1);
    wr(1, 2'b01, 16'h000F);
    @(negedge clk);
    chk("R4 clear quiet", {15'b0, irq_pulse}, 16'h0);
    wr(0, 2'b01, 16'h00F9);
    @(negedge clk);
    chk("R6 command pulse again", {15'b0, irq_pulse}, 16'h1);
    wr(0, 2'b01, 16'h00F9);
    @(negedge clk);
    chk("R5 command bit already set", {15'b0, irq_pulse}, 16'h0);

    // R11 byte enables
    wr(1, 2'b01, 16'h000F);
    wr(0, 2'b10, 16'h02FF);
    rd(0, v); chk("R11 upper byte only", v, 16'h02F9);
    rd(1, v); chk("R6 upper-byte write is command", {15'b0, v[3]}, 16'h1);

    // R7 interlock toggle, R9 refused hot-add
    wr(0, 2'b10, 16'h0600);
    rd(1, v); chk("R7 lock engaged", {15'b0, v[5]}, 16'h1);
    rd(0, v); chk("R7 toggle bit reads 0", {15'b0, v[10]}, 16'h0);
    wr(1, 2'b01, 16'h000F);
    ev(2);
    chk("R9 busy pulse", {15'b0, add_busy}, 16'h1);
    rd(1, v); chk("R9 refused add no status", v, 16'h0030);
    @(negedge clk);
    chk("R9 busy one cycle", {15'b0, add_busy}, 16'h0);
    wr(0, 2'b10, 16'h0600);
    rd(1, v); chk("R7 lock released", {15'b0, v[5]}, 16'h0);

    // R8 detach
    wr(1, 2'b01, 16'h000F);
    wr(0, 2'b10, 16'h0300);
    chk("R8 detach pulse", {15'b0, detach_req}, 16'h1);
    rd(1, v); chk("R8 presence cleared", v, 16'h000C);
    @(negedge clk);
    chk("R8 detach one cycle", {15'b0, detach_req}, 16'h0);

    // R2 back to level mode: command bit still pending and enabled
    msg_mode = 0;
    @(negedge clk);
    chk("R2 level follows pending", {15'b0, irq_level}, 16'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule